// File: doc/BRIEF.md
# Private Interrupt Pending Unit

This unit keeps the pending state of one processor's private interrupts: a bank of software-generated interrupts (IDs 0 to NUM_SGI-1) and a bank of peripheral interrupts wired to input lines (IDs NUM_SGI upward, line k being ID NUM_SGI+k). Each peripheral line is compared with its stored copy every clock. A rising transition on an edge-configured line sets a sticky latch. A level-configured line counts as pending for as long as its stored copy is high.

Software interrupt requests arrive with a target ID, a requested group and a non-secure flag. The unit checks the request against the interrupt's configured group and, when security is on, against a two-bit non-secure permission field. An accepted request sets the pending latch of that interrupt. The register file supplies every configuration value: group, group modifier, permission word, trigger mode, enable, active and priority. It also supplies a clear bitmap for the latches. From the pending, enabled and not-active set, a comparison tree picks the best interrupt.

Top module: `priv_irq_pend`

## Requirements
- R1: While rst_ni is low, every pending latch and every stored line level is 0. Out of reset, hpp_valid_o is 0 and hpp_prio_o is 8'hFF.
- R2: When an edge-configured line (edge_cfg_i bit = 1) is sampled high and its stored level is 0, its latch (pend_latch_o bit NUM_SGI+k) is 1 from the next cycle on. It stays 1 after the line falls.
- R3: A level-configured line (edge_cfg_i bit = 0) never sets its latch. Its pend_o bit equals the line value sampled at the previous clock edge.
- R4: A line that holds its stored value causes no action. An edge-configured line held high after its latch is cleared does not set the latch again until it has gone low and then high.
- R5: Group codes on sgi_grp_i are 0 = group 0, 1 = secure group 1, 2 = non-secure group 1, 3 = never matches. The configured group is non-secure group 1 if the sgi_group_i bit is 1. It is secure group 1 if that bit is 0, the sgi_grpmod_i bit is 1 and sec_dis_i is 0. Otherwise it is group 0. A secure group 1 request aimed at a group 0 interrupt is handled as a group 0 request.
- R6: After that substitution, a request whose group differs from the configured group is ignored.
- R7: The permission field of SGI n is sgi_nsacc_i[2n+1:2n]. With sec_dis_i = 0, a request with sgi_ns_i = 1 is ignored if the interrupt is group 0 and the field is 0, or if it is secure group 1 and the field is below 2. Non-secure group 1 targets need no permission.
- R8: With sec_dis_i = 1, the permission field and the group modifier have no effect.
- R9: An accepted request sets pend_latch_o[sgi_id_i] in the next cycle.
- R10: A 1 in pend_clr_i clears that latch in the next cycle. A set in the same cycle wins over the clear.
- R11: When at least one interrupt is pending, enabled and not active, hpp_valid_o is 1. hpp_id_o and hpp_prio_o then give the qualifying interrupt with the lowest prio_i value, and a tie goes to the lowest ID. This output is combinational from state and configuration.
- R12: When no interrupt qualifies, hpp_valid_o is 0, hpp_id_o is 0 and hpp_prio_o is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ppi_line_i | input | NUM_PPI | Peripheral interrupt lines |
| edge_cfg_i | input | NUM_PPI | 1 = edge-triggered, 0 = level |
| sgi_req_i | input | 1 | Software interrupt request strobe |
| sgi_id_i | input | SGI_W | Target software interrupt ID |
| sgi_grp_i | input | 2 | Requested group code |
| sgi_ns_i | input | 1 | Request comes from the non-secure side |
| sec_dis_i | input | 1 | Security disabled |
| sgi_group_i | input | NUM_SGI | Group bit per software interrupt |
| sgi_grpmod_i | input | NUM_SGI | Group modifier per software interrupt |
| sgi_nsacc_i | input | 2*NUM_SGI | Non-secure permission fields |
| pend_clr_i | input | NUM_IRQ | Latch clear bitmap |
| enable_i | input | NUM_IRQ | Interrupt enables |
| active_i | input | NUM_IRQ | Interrupt active flags |
| prio_i | input | NUM_IRQ*PRIO_W | Priority per interrupt, ID n at bits [n*PRIO_W +: PRIO_W] |
| pend_latch_o | output | NUM_IRQ | Pending latches |
| pend_o | output | NUM_IRQ | Effective pending (latch, or live level) |
| hpp_valid_o | output | 1 | A qualifying interrupt exists |
| hpp_id_o | output | ID_W | ID of best pending interrupt |
| hpp_prio_o | output | PRIO_W | Its priority, 8'hFF when none |

## Verification
The bench uses the default build: 16 software and 16 peripheral interrupts with 8-bit priorities. With these values the 4-bit target ID reaches every permission field in a full 32-bit word, and the comparison tree is a full 32-leaf tree with no padding leaves. Both trigger modes appear in one build because half the lines are set to edge and half to level. A directed phase covers group substitution, each permission threshold, the set-over-clear rule and priority ties. A random phase follows, and a behavioural model checks every output on every cycle.

// File: rtl/priv_irq_pkg.sv
package priv_irq_pkg;
  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  function automatic grp_e cfg_group(input logic grp, input logic mod, input logic sec_dis);
    if (grp) return GRP_G1NS;
    if (mod && !sec_dis) return GRP_G1S;
    return GRP_G0;
  endfunction
endpackage

// File: rtl/priv_irq_sgi_gate.sv
module priv_irq_sgi_gate
  import priv_irq_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int SGI_W   = $clog2(NUM_SGI)
) (
  input  logic                 req_i,
  input  logic [SGI_W-1:0]     id_i,
  input  logic [1:0]           grp_i,
  input  logic                 ns_i,
  input  logic                 sec_dis_i,
  input  logic [NUM_SGI-1:0]   group_i,
  input  logic [NUM_SGI-1:0]   grpmod_i,
  input  logic [2*NUM_SGI-1:0] nsacc_i,
  output logic                 accept_o,
  output logic [NUM_SGI-1:0]   set_o
);
  grp_e       cfg_grp;
  grp_e       req_grp;
  logic [1:0] field;
  logic       ns_ok;

  always_comb begin
    cfg_grp = cfg_group(group_i[id_i], grpmod_i[id_i], sec_dis_i);
    req_grp = grp_e'(grp_i);
    // secure group 1 request downgrades onto a group 0 target
    if (req_grp == GRP_G1S && cfg_grp == GRP_G0) req_grp = GRP_G0;
    field = nsacc_i[{id_i, 1'b0} +: 2];
    ns_ok = 1'b1;
    if (ns_i && !sec_dis_i) begin
      if (cfg_grp == GRP_G0 && field < 2'd1) ns_ok = 1'b0;
      if (cfg_grp == GRP_G1S && field < 2'd2) ns_ok = 1'b0;
    end
    accept_o = req_i && (req_grp == cfg_grp) && ns_ok;
    set_o    = accept_o ? (NUM_SGI'(1) << id_i) : '0;
  end
endmodule

// File: rtl/priv_irq_ppi_track.sv
module priv_irq_ppi_track #(
  parameter int NUM_PPI = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_PPI-1:0] line_i,
  input  logic [NUM_PPI-1:0] edge_cfg_i,
  input  logic [NUM_PPI-1:0] clr_i,
  output logic [NUM_PPI-1:0] level_o,
  output logic [NUM_PPI-1:0] latch_o
);
  for (genvar k = 0; k < NUM_PPI; k++) begin : g_line
    logic lvl_q;
    logic lat_q;
    logic rise;

    assign rise = line_i[k] && !lvl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q <= 1'b0;
        lat_q <= 1'b0;
      end else begin
        lvl_q <= line_i[k];
        if (rise && edge_cfg_i[k]) lat_q <= 1'b1;
        else if (clr_i[k])         lat_q <= 1'b0;
      end
    end

    assign level_o[k] = lvl_q;
    assign latch_o[k] = lat_q;
  end
endmodule

// File: rtl/priv_irq_hpp_tree.sv
module priv_irq_hpp_tree #(
  parameter int N      = 32,
  parameter int PRIO_W = 8,
  parameter int ID_W   = $clog2(N)
) (
  input  logic [N-1:0]        cand_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                valid_o,
  output logic [ID_W-1:0]     id_o,
  output logic [PRIO_W-1:0]   prio_o
);
  localparam int LVLS  = $clog2(N);
  localparam int LEAFS = 1 << LVLS;
  localparam int NODES = 2 * LEAFS - 1;

  logic [NODES-1:0] nv;
  logic [PRIO_W-1:0] np [NODES];
  logic [ID_W-1:0]   ni [NODES];

  for (genvar i = 0; i < LEAFS; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign nv[LEAFS-1+i] = cand_i[i];
      assign np[LEAFS-1+i] = prio_i[i*PRIO_W +: PRIO_W];
      assign ni[LEAFS-1+i] = ID_W'(i);
    end else begin : g_pad
      assign nv[LEAFS-1+i] = 1'b0;
      assign np[LEAFS-1+i] = '1;
      assign ni[LEAFS-1+i] = '0;
    end
  end

  // heap layout: left child always holds the lower IDs
  for (genvar j = 0; j < LEAFS - 1; j++) begin : g_node
    logic take_r;
    assign take_r = nv[2*j+2] && (!nv[2*j+1] || (np[2*j+2] < np[2*j+1]));
    assign nv[j]  = nv[2*j+1] | nv[2*j+2];
    assign np[j]  = take_r ? np[2*j+2] : np[2*j+1];
    assign ni[j]  = take_r ? ni[2*j+2] : ni[2*j+1];
  end

  assign valid_o = nv[0];
  assign prio_o  = nv[0] ? np[0] : '1;
  assign id_o    = nv[0] ? ni[0] : '0;
endmodule

// File: rtl/priv_irq_pend.sv
module priv_irq_pend
  import priv_irq_pkg::*;
#(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  parameter int PRIO_W  = 8,
  localparam int NUM_IRQ = NUM_SGI + NUM_PPI,
  localparam int SGI_W   = $clog2(NUM_SGI),
  localparam int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PPI-1:0]        ppi_line_i,
  input  logic [NUM_PPI-1:0]        edge_cfg_i,
  input  logic                      sgi_req_i,
  input  logic [SGI_W-1:0]          sgi_id_i,
  input  logic [1:0]                sgi_grp_i,
  input  logic                      sgi_ns_i,
  input  logic                      sec_dis_i,
  input  logic [NUM_SGI-1:0]        sgi_group_i,
  input  logic [NUM_SGI-1:0]        sgi_grpmod_i,
  input  logic [2*NUM_SGI-1:0]      sgi_nsacc_i,
  input  logic [NUM_IRQ-1:0]        pend_clr_i,
  input  logic [NUM_IRQ-1:0]        enable_i,
  input  logic [NUM_IRQ-1:0]        active_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  output logic [NUM_IRQ-1:0]        pend_latch_o,
  output logic [NUM_IRQ-1:0]        pend_o,
  output logic                      hpp_valid_o,
  output logic [ID_W-1:0]           hpp_id_o,
  output logic [PRIO_W-1:0]         hpp_prio_o
);
  logic [NUM_SGI-1:0] sgi_set;
  logic               sgi_accept;
  logic [NUM_SGI-1:0] sgi_lat_q;
  logic [NUM_PPI-1:0] ppi_lvl;
  logic [NUM_PPI-1:0] ppi_lat;
  logic [NUM_IRQ-1:0] cand;

  priv_irq_sgi_gate #(.NUM_SGI(NUM_SGI), .SGI_W(SGI_W)) u_gate (
    .req_i    (sgi_req_i),
    .id_i     (sgi_id_i),
    .grp_i    (sgi_grp_i),
    .ns_i     (sgi_ns_i),
    .sec_dis_i(sec_dis_i),
    .group_i  (sgi_group_i),
    .grpmod_i (sgi_grpmod_i),
    .nsacc_i  (sgi_nsacc_i),
    .accept_o (sgi_accept),
    .set_o    (sgi_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sgi_lat_q <= '0;
    else         sgi_lat_q <= (sgi_lat_q & ~pend_clr_i[NUM_SGI-1:0]) | sgi_set;
  end

  priv_irq_ppi_track #(.NUM_PPI(NUM_PPI)) u_ppi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (ppi_line_i),
    .edge_cfg_i(edge_cfg_i),
    .clr_i     (pend_clr_i[NUM_IRQ-1:NUM_SGI]),
    .level_o   (ppi_lvl),
    .latch_o   (ppi_lat)
  );

  assign pend_latch_o = {ppi_lat, sgi_lat_q};
  assign pend_o       = {ppi_lat | (~edge_cfg_i & ppi_lvl), sgi_lat_q};
  assign cand         = pend_o & enable_i & ~active_i;

  priv_irq_hpp_tree #(.N(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tree (
    .cand_i (cand),
    .prio_i (prio_i),
    .valid_o(hpp_valid_o),
    .id_o   (hpp_id_o),
    .prio_o (hpp_prio_o)
  );
endmodule

// File: rtl/priv_irq_pend_chk.sv
module priv_irq_pend_chk #(
  parameter int NUM_SGI = 16,
  parameter int NUM_PPI = 16,
  parameter int PRIO_W  = 8,
  localparam int NUM_IRQ = NUM_SGI + NUM_PPI,
  localparam int SGI_W   = $clog2(NUM_SGI),
  localparam int ID_W    = $clog2(NUM_IRQ)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_PPI-1:0] ppi_line_i,
  input logic [NUM_PPI-1:0] edge_cfg_i,
  input logic               sgi_req_i,
  input logic [SGI_W-1:0]   sgi_id_i,
  input logic [1:0]         sgi_grp_i,
  input logic [NUM_SGI-1:0] sgi_group_i,
  input logic [NUM_IRQ-1:0] pend_clr_i,
  input logic [NUM_IRQ-1:0] enable_i,
  input logic [NUM_IRQ-1:0] active_i,
  input logic [NUM_IRQ-1:0] pend_latch_o,
  input logic [NUM_IRQ-1:0] pend_o,
  input logic               hpp_valid_o,
  input logic [ID_W-1:0]    hpp_id_o,
  input logic [PRIO_W-1:0]  hpp_prio_o,
  input logic [NUM_PPI-1:0] level_i,
  input logic               accept_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (pend_latch_o == '0 && level_i == '0);
    end
  end

  p_sgi_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> pend_latch_o[$past(sgi_id_i)]);

  p_grp_mismatch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sgi_req_i && sgi_grp_i == 2'd2 && !sgi_group_i[sgi_id_i] && !pend_latch_o[sgi_id_i])
    |=> !pend_latch_o[$past(sgi_id_i)]);

  p_none_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hpp_valid_o |-> (hpp_prio_o == '1 && hpp_id_o == '0));

  p_hpp_qualifies_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpp_valid_o |-> (pend_o[hpp_id_o] && enable_i[hpp_id_o] && !active_i[hpp_id_o]));

  for (genvar k = 0; k < NUM_PPI; k++) begin : g_ppi
    p_edge_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_cfg_i[k] && ppi_line_i[k] && !level_i[k]) |=> pend_latch_o[NUM_SGI+k]);
    p_level_no_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!edge_cfg_i[k] && !pend_latch_o[NUM_SGI+k]) |=> !pend_latch_o[NUM_SGI+k]);
    p_held_no_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ppi_line_i[k] == level_i[k] && !pend_latch_o[NUM_SGI+k]) |=> !pend_latch_o[NUM_SGI+k]);
  end

  for (genvar i = 0; i < NUM_SGI; i++) begin : g_sgi
    p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_clr_i[i] && !(accept_i && sgi_id_i == SGI_W'(i))) |=> !pend_latch_o[i]);
  end
endmodule

bind priv_irq_pend priv_irq_pend_chk #(
  .NUM_SGI(NUM_SGI), .NUM_PPI(NUM_PPI), .PRIO_W(PRIO_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ppi_line_i  (ppi_line_i),
  .edge_cfg_i  (edge_cfg_i),
  .sgi_req_i   (sgi_req_i),
  .sgi_id_i    (sgi_id_i),
  .sgi_grp_i   (sgi_grp_i),
  .sgi_group_i (sgi_group_i),
  .pend_clr_i  (pend_clr_i),
  .enable_i    (enable_i),
  .active_i    (active_i),
  .pend_latch_o(pend_latch_o),
  .pend_o      (pend_o),
  .hpp_valid_o (hpp_valid_o),
  .hpp_id_o    (hpp_id_o),
  .hpp_prio_o  (hpp_prio_o),
  .level_i     (ppi_lvl),
  .accept_i    (sgi_accept)
);

// File: tb/priv_irq_pend_test.sv
`timescale 1ns/100ps
module priv_irq_pend_test;
  localparam int NS = 16;
  localparam int NP = 16;
  localparam int NI = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] line = '0;
  logic [NP-1:0] edge_cfg = 16'h00FF;
  logic          req = 1'b0;
  logic [3:0]    req_id = '0;
  logic [1:0]    req_grp = '0;
  logic          req_ns = 1'b0;
  logic          sec_dis = 1'b0;
  logic [NS-1:0] grp_bits = 16'hFFFC;
  logic [NS-1:0] mod_bits = 16'h0002;
  logic [31:0]   nsacc = 32'h0000_0005;
  logic [NI-1:0] clr = '0;
  logic [NI-1:0] en = '1;
  logic [NI-1:0] act = '0;
  logic [NI*8-1:0] prio = {NI{8'hC0}};
  logic [NI-1:0] lat_o, pend_o;
  logic          hv;
  logic [4:0]    hid;
  logic [7:0]    hp;

  int errors = 0;
  int checks = 0;
  logic [NI-1:0] m_lat = '0;
  logic [NP-1:0] m_lvl = '0;

  always #2.5 clk = ~clk;

  priv_irq_pend uut (
    .clk_i(clk), .rst_ni(rst_n), .ppi_line_i(line), .edge_cfg_i(edge_cfg),
    .sgi_req_i(req), .sgi_id_i(req_id), .sgi_grp_i(req_grp), .sgi_ns_i(req_ns),
    .sec_dis_i(sec_dis), .sgi_group_i(grp_bits), .sgi_grpmod_i(mod_bits),
    .sgi_nsacc_i(nsacc), .pend_clr_i(clr), .enable_i(en), .active_i(act),
    .prio_i(prio), .pend_latch_o(lat_o), .pend_o(pend_o), .hpp_valid_o(hv),
    .hpp_id_o(hid), .hpp_prio_o(hp)
  );

  function automatic bit m_accept();
    int cg, rg, f;
    if (!req) return 0;
    if (grp_bits[req_id]) cg = 2;
    else if (mod_bits[req_id] && !sec_dis) cg = 1;
    else cg = 0;
    rg = int'(req_grp);
    if (rg == 1 && cg == 0) rg = 0;
    if (rg != cg) return 0;
    f = int'(nsacc[2*req_id +: 2]);
    if (req_ns && !sec_dis) begin
      if (cg == 0 && f < 1) return 0;
      if (cg == 1 && f < 2) return 0;
    end
    return 1;
  endfunction

  // reference state update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat <= '0;
      m_lvl <= '0;
    end else begin
      logic [NI-1:0] nl;
      nl = m_lat & ~clr;
      for (int k = 0; k < NP; k++) begin
        if (edge_cfg[k] && line[k] && !m_lvl[k]) nl[NS+k] = 1'b1;
        else if (clr[NS+k]) nl[NS+k] = 1'b0;
        else nl[NS+k] = m_lat[NS+k];
      end
      if (m_accept()) nl[req_id] = 1'b1;
      m_lat <= nl;
      m_lvl <= line;
    end
  end

  task automatic check(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  // cycle compare against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      logic [NI-1:0] mp, mc;
      int bi, bp;
      mp = m_lat | {~edge_cfg & m_lvl, {NS{1'b0}}};
      mc = mp & en & ~act;
      bi = -1; bp = 256;
      for (int i = 0; i < NI; i++)
        if (mc[i] && int'(prio[i*8 +: 8]) < bp) begin bi = i; bp = int'(prio[i*8 +: 8]); end
      check("R2 R3 R9 R10 model latch", lat_o, m_lat);
      check("R3 model pend", pend_o, mp);
      if (bi < 0) check("R12 model none", {23'd0, hv, hid, hp}, {23'd0, 1'b0, 5'd0, 8'hFF});
      else check("R11 model hpp", {23'd0, hv, hid, hp}, {23'd0, 1'b1, 5'(bi), 8'(bp)});
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic sgi(input int id, input int g, input bit ns);
    req = 1'b1; req_id = 4'(id); req_grp = 2'(g); req_ns = ns;
    cyc();
    req = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(2);
    check("R1 reset latch", lat_o, 32'h0);
    rst_n = 1'b1;
    cyc();
    check("R1 reset hpp", {hv, hp}, {1'b0, 8'hFF});
    check("R12 idle id", 32'(hid), 32'd0);

    line[0] = 1'b1; cyc();
    check("R2 edge latch", 32'(lat_o[16]), 1);
    line[0] = 1'b0; cyc();
    check("R2 latch kept", 32'(lat_o[16]), 1);
    check("R11 single", 32'(hid), 16);

    line[8] = 1'b1; cyc();
    check("R3 level pend", {pend_o[24], lat_o[24]}, 2'b10);
    line[8] = 1'b0; cyc();
    check("R3 level drop", 32'(pend_o[24]), 0);

    line[1] = 1'b1; cyc();
    check("R4 set", 32'(lat_o[17]), 1);
    clr[17] = 1'b1; cyc(); clr = '0;
    check("R4 cleared", 32'(lat_o[17]), 0);
    cyc(2);
    check("R4 held high no relatch", 32'(lat_o[17]), 0);
    line[1] = 1'b0; cyc(); line[1] = 1'b1; cyc();
    check("R4 new edge", 32'(lat_o[17]), 1);

    sgi(0, 1, 0);
    check("R5 downgrade accepted", 32'(lat_o[0]), 1);
    sgi(2, 0, 0);
    check("R6 g0 on g1ns", 32'(lat_o[2]), 0);
    sgi(1, 0, 0);
    check("R6 g0 on g1s", 32'(lat_o[1]), 0);
    sgi(5, 1, 0);
    check("R6 g1s on g1ns", 32'(lat_o[5]), 0);
    sgi(6, 3, 0);
    check("R6 code 3", 32'(lat_o[6]), 0);

    clr[0] = 1'b1; cyc(); clr = '0;
    sgi(0, 0, 1);
    check("R7 g0 field1", 32'(lat_o[0]), 1);
    clr[0] = 1'b1; cyc(); clr = '0;
    nsacc[1:0] = 2'd0;
    sgi(0, 0, 1);
    check("R7 g0 field0", 32'(lat_o[0]), 0);
    sgi(1, 1, 1);
    check("R7 g1s field1", 32'(lat_o[1]), 0);
    nsacc[3:2] = 2'd2;
    sgi(1, 1, 1);
    check("R7 g1s field2", 32'(lat_o[1]), 1);
    sgi(2, 2, 1);
    check("R7 g1ns free", 32'(lat_o[2]), 1);

    clr = 32'h0000_FFFF; cyc(); clr = '0;
    sec_dis = 1'b1; nsacc = '0;
    sgi(1, 1, 1);
    check("R8 modifier ignored", 32'(lat_o[1]), 1);
    sgi(0, 0, 1);
    check("R8 field ignored", 32'(lat_o[0]), 1);
    sec_dis = 1'b0;

    clr[3] = 1'b1; sgi(3, 2, 0); clr = '0;
    check("R10 set wins", 32'(lat_o[3]), 1);
    clr[3] = 1'b1; cyc(); clr = '0;
    check("R10 clear", 32'(lat_o[3]), 0);

    clr = '1; line = '0; cyc(); clr = '0; cyc();
    check("R10 clear all", lat_o, 32'h0);
    prio[3*8 +: 8] = 8'h40; prio[4*8 +: 8] = 8'h40; prio[16*8 +: 8] = 8'h40;
    sgi(4, 2, 0); sgi(3, 2, 0);
    line[0] = 1'b1; cyc();
    check("R11 tie low id", {24'd0, 3'd0, hid}, 32'd3);
    check("R11 prio", 32'(hp), 32'h40);
    act[3] = 1'b1; #1;
    check("R11 active skipped", 32'(hid), 4);
    en[4] = 1'b0; #1;
    check("R11 disabled skipped", 32'(hid), 16);
    prio[24*8 +: 8] = 8'h10; line[8] = 1'b1; cyc();
    check("R11 level wins", {hid, hp}, {5'd24, 8'h10});
    en = '0; #1;
    check("R12 none", {hv, hid, hp}, {1'b0, 5'd0, 8'hFF});
    en = '1; act = '0;

    for (int n = 0; n < 400; n++) begin
      line     = 16'($urandom);
      edge_cfg = 16'($urandom);
      req      = 1'($urandom);
      req_id   = 4'($urandom);
      req_grp  = 2'($urandom);
      req_ns   = 1'($urandom);
      sec_dis  = ($urandom % 4) == 0;
      grp_bits = 16'($urandom);
      mod_bits = 16'($urandom);
      nsacc    = $urandom;
      clr      = $urandom & $urandom;
      en       = $urandom | $urandom;
      act      = $urandom & $urandom;
      for (int i = 0; i < NI; i++) prio[i*8 +: 8] = 8'($urandom % 8) << 5;
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule